// File: doc/BRIEF.md
# Keyed-Clear Watchdog Timer

This block is a bus-mapped watchdog. A selected tick source is divided by a fixed
factor of 32; each divided tick advances a count whose terminal value is a power of two
chosen by a configuration field. If the count reaches its terminal value while the
timer is enabled, the block pulses a reset request to the system reset logic,
records the cause in a sticky status register and starts counting again from zero.

Software keeps the system alive by writing a fixed 16-bit key into the upper half of
the control word. With windowed mode on, a key that arrives too early is itself treated
as a fault. Both registers have set and clear alias addresses. A write to an alias
changes only the bits written as 1.

Register map (byte addresses): control 0x00, control-clear 0x04, control-set 0x08,
status 0x10, status-clear 0x14, status-set 0x18. The control word reads as enable at
bit 15, tick-divider exponent at bits 12:8, source select at bits 7:6 and window mode at
bit 0. All other bits read 0. The status word holds the timeout flag at bit 4, the
sleep flag at bit 3 and the idle flag at bit 2.

Top module: `kwdt_top`

## Requirements
- R1: After reset, control reads enable=0, window=0 with the configuration fields, status reads 0 and `wdt_rst_req` is 0.
- R2: While enable (control bit 15) is 0 the count holds: no reset request is raised and counting resumes from the held value once enable returns to 1.
- R3: With enable set, `wdt_rst_req` is high for exactly one cycle, 32·2^P selected ticks after the last restart, where P is bits 12:8. The count then restarts from zero.
- R4: A write to address 0x00 with byte enables 4'b1100 and data[31:16]=16'h5743 restarts the divider and the count from zero.
- R5: Any other value written to the upper half-word of control leaves the timeout unchanged.
- R6: Only `src_tick[S]` advances the divider, where S is control bits 7:6.
- R7: Bits 12:8 and 7:6 are loaded from `cfg_postsc` and `cfg_clksel` while `rst` is high. Later changes to those inputs and writes to those bits have no effect.
- R8: With window (bit 0) and enable set, a key write while the count is below 3/4 of the terminal value pulses `wdt_rst_req` in the next cycle, sets the timeout flag and restarts the count.
- R9: With window set, a key write at or beyond 3/4 of the terminal value restarts the count and raises no request.
- R10: Each request sets status bit 4. It also sets bit 2 if `sys_idle` is high and bit 3 if `sys_sleep` is high at that time. The flags stay set until software clears them.
- R11: Writing 1s to a set alias (0x08, 0x18) sets those bits. Writing 1s to a clear alias (0x04, 0x14) clears them. A plain write to status (0x10) loads bits 4:2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_clksel | input | 2 | Source select loaded during reset |
| cfg_postsc | input | 5 | Terminal exponent loaded during reset |
| src_tick | input | 4 | Tick enables from the candidate sources |
| sys_idle | input | 1 | System is in idle mode |
| sys_sleep | input | 1 | System is in sleep mode |
| bus_sel | input | 1 | Bus access valid |
| bus_we | input | 1 | Bus access is a write |
| bus_addr | input | 5 | Byte address |
| bus_be | input | 4 | Byte enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational on bus_addr |
| wdt_rst_req | output | 1 | One-cycle reset request |

## Verification
The assertions assume that the configuration inputs are valid while `rst` is high. They also assume that a key write is a single-cycle access with exactly the upper two byte enables set. The bench loads a small exponent (2), so that a full period takes 128 selected ticks. It issues every bus access as a single cycle and holds the tick of the selected source high, apart from one stretch where that source is idle and the other sources toggle.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
    localparam int PS_W    = 5;
    localparam int CS_W    = 2;
    localparam int NSRC    = 1 << CS_W;
    localparam int PRE_DIV = 32;
    localparam int PRE_W   = $clog2(PRE_DIV);
    localparam int CNT_W   = 1 << PS_W;
    localparam int ADDR_W  = 5;
    localparam int DATA_W  = 32;

    localparam logic [15:0] KEEP_KEY = 16'h5743;

    localparam int B_EN   = 15;
    localparam int B_PS   = 8;
    localparam int B_CS   = 6;
    localparam int B_WIN  = 0;
    localparam int B_FLAG = 2;

    typedef enum logic [2:0] {
        RG_CTRL = 3'd0,
        RG_CCLR = 3'd1,
        RG_CSET = 3'd2,
        RG_RSV3 = 3'd3,
        RG_STAT = 3'd4,
        RG_SCLR = 3'd5,
        RG_SSET = 3'd6,
        RG_RSV7 = 3'd7
    } reg_e;

    typedef struct packed {
        logic            en;
        logic            win;
        logic [PS_W-1:0] ps;
        logic [CS_W-1:0] cs;
    } ctrl_t;

    // flags: [2]=timeout, [1]=sleep, [0]=idle
    typedef logic [2:0] flags_t;

    function automatic logic [CNT_W:0] term_of(input logic [PS_W-1:0] ps);
        return (CNT_W+1)'(1) << ps;
    endfunction

    function automatic logic [CNT_W:0] open_of(input logic [PS_W-1:0] ps);
        return term_of(ps) - (term_of(ps) >> 2);
    endfunction
endpackage

// File: rtl/kwdt_regs.sv
module kwdt_regs
    import kwdt_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic [CS_W-1:0]        cfg_clksel,
    input  logic [PS_W-1:0]        cfg_postsc,
    input  logic                   bus_sel,
    input  logic                   bus_we,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [3:0]             bus_be,
    input  logic [DATA_W-1:0]      bus_wdata,
    input  logic                   evt,
    input  logic                   sys_idle,
    input  logic                   sys_sleep,
    output ctrl_t                  ctrl,
    output flags_t                 flags,
    output logic                   key_hit,
    output logic [DATA_W-1:0]      rdata
);
    reg_e   rsel;
    logic   wr;
    flags_t flags_nxt;
    ctrl_t  ctrl_nxt;
    flags_t wflags;
    logic   wdata_unused;

    assign rsel   = reg_e'(bus_addr[4:2]);
    assign wr     = bus_sel && bus_we && (bus_addr[1:0] == 2'b00);
    assign wflags = bus_wdata[B_FLAG+2:B_FLAG];
    assign key_hit = wr && (rsel == RG_CTRL) && (bus_be == 4'b1100)
                     && (bus_wdata[31:16] == KEEP_KEY);
    assign wdata_unused = ^{bus_wdata[14:5], bus_wdata[1]};

    always_comb begin
        ctrl_nxt  = ctrl;
        flags_nxt = flags;
        if (wr) begin
            case (rsel)
                RG_CTRL: begin
                    if (bus_be[1]) ctrl_nxt.en  = bus_wdata[B_EN];
                    if (bus_be[0]) ctrl_nxt.win = bus_wdata[B_WIN];
                end
                RG_CSET: begin
                    if (bus_wdata[B_EN])  ctrl_nxt.en  = 1'b1;
                    if (bus_wdata[B_WIN]) ctrl_nxt.win = 1'b1;
                end
                RG_CCLR: begin
                    if (bus_wdata[B_EN])  ctrl_nxt.en  = 1'b0;
                    if (bus_wdata[B_WIN]) ctrl_nxt.win = 1'b0;
                end
                RG_STAT: flags_nxt = wflags;
                RG_SSET: flags_nxt = flags | wflags;
                RG_SCLR: flags_nxt = flags & ~wflags;
                default: ;
            endcase
        end
        if (evt) begin
            flags_nxt[2] = 1'b1;
            if (sys_sleep) flags_nxt[1] = 1'b1;
            if (sys_idle)  flags_nxt[0] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl.en  <= 1'b0;
            ctrl.win <= 1'b0;
            ctrl.ps  <= cfg_postsc;
            ctrl.cs  <= cfg_clksel;
            flags    <= '0;
        end else begin
            ctrl  <= ctrl_nxt;
            flags <= flags_nxt;
        end
    end

    always_comb begin
        rdata = '0;
        case (rsel)
            RG_CTRL: begin
                rdata[B_EN]             = ctrl.en;
                rdata[B_PS+PS_W-1:B_PS] = ctrl.ps;
                rdata[B_CS+CS_W-1:B_CS] = ctrl.cs;
                rdata[B_WIN]            = ctrl.win;
            end
            RG_STAT: rdata[B_FLAG+2:B_FLAG] = flags;
            default: ;
        endcase
    end

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rst |=> $stable(ctrl.ps) && $stable(ctrl.cs));  // R7
    AST_FLAG_ON_EVT: assert property (@(posedge clk) disable iff (rst)
        evt |=> flags[2]);  // R10
endmodule

// File: rtl/kwdt_count.sv
module kwdt_count
    import kwdt_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  ctrl_t           ctrl,
    input  logic [NSRC-1:0] src_tick,
    input  logic            key_hit,
    output logic            evt
);
    logic [PRE_W-1:0] presc;
    logic [CNT_W-1:0] post_cnt;
    logic             sel_tick, pre_last, wrap, early;
    logic [CNT_W:0]   term;

    assign term     = term_of(ctrl.ps);
    assign sel_tick = src_tick[ctrl.cs];
    assign pre_last = (presc == PRE_W'(PRE_DIV - 1));
    assign wrap     = ctrl.en && sel_tick && pre_last
                      && ({1'b0, post_cnt} == (term - (CNT_W+1)'(1)));
    assign early    = key_hit && ctrl.en && ctrl.win
                      && ({1'b0, post_cnt} < open_of(ctrl.ps));
    assign evt      = (wrap && !key_hit) || early;

    always_ff @(posedge clk) begin
        if (rst || key_hit || wrap) begin
            presc    <= '0;
            post_cnt <= '0;
        end else if (ctrl.en && sel_tick) begin
            presc <= pre_last ? '0 : presc + 1'b1;
            if (pre_last) post_cnt <= post_cnt + 1'b1;
        end
    end

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !ctrl.en && !key_hit |=> $stable(post_cnt) && $stable(presc));  // R2
    AST_BELOW_TERM: assert property (@(posedge clk) disable iff (rst)
        {1'b0, post_cnt} < term);  // R3
    AST_KEY_RESTART: assert property (@(posedge clk) disable iff (rst)
        key_hit |=> (post_cnt == '0) && (presc == '0));  // R4
    AST_NO_EVT_OFF: assert property (@(posedge clk) disable iff (rst)
        !ctrl.en |-> !evt);  // R2
endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
    import kwdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cfg_clksel,
    input  logic [4:0]        cfg_postsc,
    input  logic [3:0]        src_tick,
    input  logic              sys_idle,
    input  logic              sys_sleep,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [4:0]        bus_addr,
    input  logic [3:0]        bus_be,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              wdt_rst_req
);
    ctrl_t  ctrl;
    flags_t flags;
    logic   key_hit;
    logic   evt;

    kwdt_regs u_regs (
        .clk(clk), .rst(rst),
        .cfg_clksel(cfg_clksel), .cfg_postsc(cfg_postsc),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_be(bus_be), .bus_wdata(bus_wdata),
        .evt(evt), .sys_idle(sys_idle), .sys_sleep(sys_sleep),
        .ctrl(ctrl), .flags(flags), .key_hit(key_hit), .rdata(bus_rdata)
    );

    kwdt_count u_count (
        .clk(clk), .rst(rst), .ctrl(ctrl), .src_tick(src_tick),
        .key_hit(key_hit), .evt(evt)
    );

    always_ff @(posedge clk) begin
        if (rst) wdt_rst_req <= 1'b0;
        else     wdt_rst_req <= evt;
    end

    AST_REQ_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        wdt_rst_req |-> flags[2]);  // R10
    AST_REQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        $rose(wdt_rst_req) |-> $past(ctrl.en));  // R3
endmodule

// File: tb/test_kwdt_top.sv
module test_kwdt_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [4:0] A_CTRL = 5'h00, A_CCLR = 5'h04, A_CSET = 5'h08;
    localparam logic [4:0] A_STAT = 5'h10, A_SCLR = 5'h14, A_SSET = 5'h18;
    localparam int PERIOD = 128;

    logic clk = 0, rst = 1;
    logic [1:0] cfg_clksel = 2'd1;
    logic [4:0] cfg_postsc = 5'd2;
    logic [3:0] src_tick = 4'b0010;
    logic sys_idle = 0, sys_sleep = 0;
    logic bus_sel = 0, bus_we = 0;
    logic [4:0] bus_addr = '0;
    logic [3:0] bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic wdt_rst_req;

    kwdt_top i_kwdt_top (
        .clk(clk), .rst(rst), .cfg_clksel(cfg_clksel), .cfg_postsc(cfg_postsc),
        .src_tick(src_tick), .sys_idle(sys_idle), .sys_sleep(sys_sleep),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr), .bus_be(bus_be),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wdt_rst_req(wdt_rst_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        string       tag;
        int          src;
        logic [31:0] exp;
    } item_t;
    item_t q[$];
    int n_chk = 0, n_err = 0;
    bit done = 0;

    always @(negedge clk) begin
        item_t it;
        logic [31:0] act;
        while (q.size() > 0) begin
            it  = q.pop_front();
            act = (it.src == 1) ? {31'b0, wdt_rst_req} : bus_rdata;
            n_chk++;
            if (act !== it.exp) begin
                n_err++;
                $display("FAIL %s cyc=%0d actual=%h expected=%h", it.tag, cyc, act, it.exp);
            end
        end
    end

    task automatic chk(input string tag, input int src, input logic [4:0] a,
                       input logic [31:0] exp);
        item_t it;
        if (src == 0) bus_addr = a;
        it.tag = tag; it.src = src; it.exp = exp;
        q.push_back(it);
    endtask

    task automatic wait_to(input int t);
        while (cyc < t) begin @(posedge clk); #1; end
    endtask

    task automatic wr(input logic [4:0] a, input logic [3:0] be,
                      input logic [31:0] d, output int at);
        bus_sel = 1; bus_we = 1; bus_addr = a; bus_be = be; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 0; bus_we = 0; at = cyc;
    endtask

    task automatic expect_expiry(input string tag, input int t);
        wait_to(t - 1); chk(tag, 1, '0, 32'd0);
        wait_to(t);     chk(tag, 1, '0, 32'd1);
        wait_to(t + 1); chk(tag, 1, '0, 32'd0);
    endtask

    initial begin
        int w, k, d, e, r;
        repeat (3) @(posedge clk);
        #1; rst = 0;
        cfg_clksel = 2'd3; cfg_postsc = 5'd7;
        // R1: reset state
        chk("R1 ctrl", 0, A_CTRL, 32'h0000_0240);
        chk("R1 req", 1, '0, 32'd0);
        wait_to(cyc + 1);
        chk("R1 stat", 0, A_STAT, 32'd0);
        wait_to(cyc + 1);
        // R7: config fields read-only
        wr(A_CTRL, 4'hF, 32'h0000_1FC0, w);
        chk("R7 ctrl", 0, A_CTRL, 32'h0000_0240);
        wait_to(cyc + 1);
        // R3: enable then timeout
        wr(A_CSET, 4'hF, 32'h0000_8000, w);
        expect_expiry("R3 timeout", w + PERIOD);
        chk("R10 stat", 0, A_STAT, 32'h10);
        expect_expiry("R3 restart", w + 2*PERIOD);
        // R4 + R5: key then non-key
        wr(A_CTRL, 4'b1100, 32'h5743_0000, k);
        wr(A_CTRL, 4'b1100, 32'h1234_0000, d);
        expect_expiry("R4 R5 key", k + PERIOD);
        // R2: disable holds the count
        wr(A_CTRL, 4'b1100, 32'h5743_0000, k);
        wait_to(k + 63);
        wr(A_CCLR, 4'hF, 32'h0000_8000, d);
        wait_to(d + 64); chk("R2 off", 1, '0, 32'd0);
        wait_to(d + 200); chk("R2 off", 1, '0, 32'd0);
        wait_to(cyc + 1); chk("R2 ctrl", 0, A_CTRL, 32'h0000_0240);
        wait_to(cyc + 1);
        wr(A_CSET, 4'hF, 32'h0000_8000, e);
        expect_expiry("R2 resume", e + PERIOD - (d - k));
        // R6: only selected source counts
        wr(A_CTRL, 4'b1100, 32'h5743_0000, k);
        src_tick = 4'b1101;
        wait_to(k + 50);
        src_tick = 4'b0010;
        expect_expiry("R6 select", k + 50 + PERIOD);
        // R8: early key in window mode, with idle flag
        wr(A_SCLR, 4'hF, 32'h0000_001C, w);
        wr(A_CSET, 4'hF, 32'h0000_0001, w);
        sys_idle = 1;
        wr(A_CTRL, 4'b1100, 32'h5743_0000, k);
        chk("R8 early", 1, '0, 32'd1);
        wait_to(k + 1); chk("R8 pulse", 1, '0, 32'd0);
        chk("R10 idle", 0, A_STAT, 32'h14);
        sys_idle = 0;
        // R9: key in final quarter
        wait_to(k + 100);
        wr(A_SCLR, 4'hF, 32'h0000_001C, w);
        wr(A_CTRL, 4'b1100, 32'h5743_0000, k);
        chk("R9 late", 1, '0, 32'd0);
        wait_to(k + 1); chk("R9 late", 1, '0, 32'd0);
        sys_sleep = 1;
        expect_expiry("R9 timeout", k + PERIOD);
        chk("R10 sleep", 0, A_STAT, 32'h18);
        sys_sleep = 0;
        // R8/R9 window boundary
        r = k + PERIOD;
        wait_to(r + 95);
        wr(A_CTRL, 4'b1100, 32'h5743_0000, k);
        chk("R8 boundary", 1, '0, 32'd1);
        r = k;
        wait_to(r + 96);
        wr(A_CTRL, 4'b1100, 32'h5743_0000, k);
        chk("R9 boundary", 1, '0, 32'd0);
        wait_to(k + 1); chk("R9 boundary", 1, '0, 32'd0);
        // R11: aliases
        wr(A_CCLR, 4'hF, 32'h0000_8001, w);
        chk("R11 ctrl clr", 0, A_CTRL, 32'h0000_0240);
        wait_to(cyc + 1);
        chk("R10 sticky", 0, A_STAT, 32'h18);
        wait_to(cyc + 1);
        wr(A_SSET, 4'hF, 32'h0000_0004, w);
        chk("R11 set", 0, A_STAT, 32'h1C);
        wait_to(cyc + 1);
        wr(A_SCLR, 4'hF, 32'h0000_0010, w);
        chk("R11 clr", 0, A_STAT, 32'h0C);
        wait_to(cyc + 1);
        wr(A_STAT, 4'hF, 32'h0000_0010, w);
        chk("R11 plain", 0, A_STAT, 32'h10);
        wait_to(cyc + 1);
        wr(A_CSET, 4'hF, 32'h0000_0001, w);
        chk("R11 ctrl set", 0, A_CTRL, 32'h0000_0241);
        wait_to(cyc + 2);
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule